// File: doc/BRIEF.md
# Three-Wire Serial Configuration Register Slave

This block is the configuration port of a converter-style device. A host reaches a small byte-wide register array through three pins: a serial clock, an active-low select and a single data line that carries data in both directions. Each frame opens with a 16-bit instruction word. The word holds a read flag, a two-bit length code and a 13-bit register address. One or more data bytes follow the instruction. A write frame stores each received byte in the array. In a read frame the block takes over the data line at the end of the instruction and shifts register contents out to the host.

The pins are oversampled by the system clock. Each pin passes through a synchronizer, and the clock edges are detected in the system clock domain, so the whole block runs in one clock domain. Bit order can be switched between MSB-first and LSB-first by writing a bit in configuration register 0. In a multi-byte transfer the register address steps after each byte. The direction of the step depends on the bit order.

Top module: `spi_cfg_slave`

## Requirements
- R1: After reset the data output enable is low, every register reads 0x00 and the port uses MSB-first order.
- R2: The input is sampled on rising serial-clock edges while select is low. In MSB-first order the instruction is sent bit 15 first and holds {read flag (bit 15, 1 = read), length code (bits 14:13), address (bits 12:0)}. The data bytes that follow are also sent MSB first.
- R3: Length code 00, 01 or 10 gives 1, 2 or 3 data bytes. After the last counted byte the frame is over, and further clocks are ignored until select goes high.
- R4: In MSB-first order the address decrements by one after each data byte and wraps modulo 2^13.
- R5: In a read frame the output enable rises at the first falling clock edge after the 16th instruction bit. Each data bit is launched on a falling edge, and the data bytes are the register contents at the stepped addresses.
- R6: Length code 11 streams bytes until select rises. A byte that is only partly received when select rises is discarded.
- R7: In a counted frame, select may go high between data bytes without ending the frame. The transfer resumes when select returns low.
- R8: Bit 6 of register 0 selects LSB-first order (1 = LSB first). The value is taken at the start of each frame. In LSB-first order the instruction is sent bit 0 first, so address bit 0 comes first and the read flag comes last. Data bytes are sent bit 0 first, and the address increments after each byte.
- R9: Addresses at or above the array depth are not stored. Writes to them change no register, and reads from them return 0x00.
- R10: The output enable is low in write frames and whenever select is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock used to oversample the serial pins |
| rst_ni | input | 1 | Asynchronous active-low reset |
| sclk_i | input | 1 | Serial clock from the host |
| csb_ni | input | 1 | Active-low select |
| sdio_i | input | 1 | Input side of the bidirectional data pin |
| sdio_o | output | 1 | Output side of the bidirectional data pin |
| sdio_oe_o | output | 1 | Output enable for the data pin (1 = block drives) |

## Verification
The bench targets the points where a frame changes shape. It sends a one-byte write followed by an extra byte, which a design that ignores the length code would store at the next address. It raises select between bytes of a counted write, which a design that treats select-high as the end of the frame would cut short. It ends a stream with half a byte, which a design would write if it did not discard partial bytes. It also checks address wrap and the array boundary, where an unguarded design would alias 0x100 onto register 0. The bit-order switch is covered in both directions with writes and readbacks: a design that reverses only the data bits, or that steps the address the wrong way in one of the orders, returns readback bytes in the wrong order.

// File: rtl/spi_cfg_pkg.sv
package spi_cfg_pkg;
  localparam int INSTR_BITS = 16;
  localparam int BYTE_BITS  = 8;
  localparam int ADDR_BITS  = 13;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_INSTR = 2'd1,
    ST_DATA  = 2'd2,
    ST_DONE  = 2'd3
  } frame_st_e;

  typedef enum logic [1:0] {
    LEN_ONE    = 2'b00,
    LEN_TWO    = 2'b01,
    LEN_THREE  = 2'b10,
    LEN_STREAM = 2'b11
  } len_code_e;

  typedef struct packed {
    logic                 rd;
    logic [1:0]           len;
    logic [ADDR_BITS-1:0] addr;
  } instr_t;
endpackage

// File: rtl/spi_cfg_sync.sv
module spi_cfg_sync #(
  parameter int             W       = 3,
  parameter int             STAGES  = 2,
  parameter logic [W-1:0]   RST_VAL = '0
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] din_i,
  output logic [W-1:0] dout_o
);
  for (genvar b = 0; b < W; b++) begin : g_bit
    logic [STAGES-1:0] chain_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) chain_q <= {STAGES{RST_VAL[b]}};
      else         chain_q <= {chain_q[STAGES-2:0], din_i[b]};
    end
    assign dout_o[b] = chain_q[STAGES-1];
  end
endmodule

// File: rtl/spi_cfg_regs.sv
module spi_cfg_regs #(
  parameter int DEPTH    = 16,
  parameter int ADDR_W   = 13,
  parameter int CFG_ADDR = 0,
  parameter int LSB_BIT  = 6
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] wr_addr_i,
  input  logic [7:0]        wr_data_i,
  input  logic [ADDR_W-1:0] rd_addr_i,
  output logic [7:0]        rd_data_o,
  output logic              lsb_first_o
);
  localparam int                IDX_W   = $clog2(DEPTH);
  localparam logic [ADDR_W-1:0] DEPTH_A = ADDR_W'(DEPTH);

  logic [DEPTH-1:0][7:0] mem_q;

  for (genvar g = 0; g < DEPTH; g++) begin : g_reg
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                                 mem_q[g] <= 8'h00;
      else if (we_i && wr_addr_i == ADDR_W'(g))    mem_q[g] <= wr_data_i;
    end
  end

  assign rd_data_o   = (rd_addr_i < DEPTH_A) ? mem_q[rd_addr_i[IDX_W-1:0]] : 8'h00;
  assign lsb_first_o = mem_q[CFG_ADDR][LSB_BIT];

  // R8: order bit only moves on a write to the config register
  p_cfg_hold_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(we_i && wr_addr_i == ADDR_W'(CFG_ADDR)) |=> $stable(lsb_first_o));
  // R9: out-of-range writes leave the array untouched
  p_oob_write_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (we_i && wr_addr_i >= DEPTH_A) |=> $stable(mem_q));
endmodule

// File: rtl/spi_cfg_frame.sv
module spi_cfg_frame
  import spi_cfg_pkg::*;
(
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 sclk_i,
  input  logic                 csb_i,
  input  logic                 sdi_i,
  input  logic                 lsb_cfg_i,
  input  logic [7:0]           rd_data_i,
  output logic [ADDR_BITS-1:0] rd_addr_o,
  output logic                 we_o,
  output logic [ADDR_BITS-1:0] wr_addr_o,
  output logic [7:0]           wr_data_o,
  output logic                 sdo_o,
  output logic                 sdo_oe_o
);
  localparam logic [3:0] LAST_INSTR = 4'(INSTR_BITS - 1);
  localparam logic [3:0] LAST_DATA  = 4'(BYTE_BITS - 1);

  frame_st_e             st_q;
  logic                  sclk_d, csb_d;
  logic [3:0]            bit_cnt_q;
  logic [INSTR_BITS-1:0] instr_q, instr_nxt;
  logic [7:0]            rx_q, rx_nxt;
  logic [ADDR_BITS-1:0]  addr_q, addr_step;
  logic [1:0]            left_q;
  logic                  rd_q, stream_q, lsb_q, sdo_q, oe_q;
  logic                  rx_edge, tx_edge, csb_rise, lsb_now, byte_done;
  logic [2:0]            tx_sel;
  instr_t                dec;

  assign rx_edge  = sclk_i & ~sclk_d & ~csb_i;
  assign tx_edge  = ~sclk_i & sclk_d & ~csb_i;
  assign csb_rise = csb_i & ~csb_d;

  // order is fixed for the whole frame once its first bit arrives
  assign lsb_now   = (st_q == ST_IDLE) ? lsb_cfg_i : lsb_q;
  assign instr_nxt = lsb_now ? {sdi_i, instr_q[INSTR_BITS-1:1]}
                             : {instr_q[INSTR_BITS-2:0], sdi_i};
  assign rx_nxt    = lsb_q ? {sdi_i, rx_q[7:1]} : {rx_q[6:0], sdi_i};
  assign dec       = instr_t'(instr_nxt);
  assign addr_step = lsb_q ? addr_q + 1'b1 : addr_q - 1'b1;
  assign byte_done = rx_edge && (st_q == ST_DATA) && (bit_cnt_q == LAST_DATA);
  assign tx_sel    = lsb_q ? bit_cnt_q[2:0] : ~bit_cnt_q[2:0];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q      <= ST_IDLE;
      sclk_d    <= 1'b0;
      csb_d     <= 1'b1;
      bit_cnt_q <= '0;
      instr_q   <= '0;
      rx_q      <= '0;
      addr_q    <= '0;
      left_q    <= '0;
      rd_q      <= 1'b0;
      stream_q  <= 1'b0;
      lsb_q     <= 1'b0;
      sdo_q     <= 1'b0;
      oe_q      <= 1'b0;
    end else begin
      sclk_d <= sclk_i;
      csb_d  <= csb_i;
      case (st_q)
        ST_IDLE: begin
          if (rx_edge) begin
            instr_q   <= instr_nxt;
            lsb_q     <= lsb_cfg_i;
            bit_cnt_q <= 4'd1;
            st_q      <= ST_INSTR;
          end
        end
        ST_INSTR: begin
          if (rx_edge) begin
            instr_q <= instr_nxt;
            if (bit_cnt_q == LAST_INSTR) begin
              addr_q    <= dec.addr;
              rd_q      <= dec.rd;
              left_q    <= dec.len;
              stream_q  <= (dec.len == LEN_STREAM);
              bit_cnt_q <= '0;
              st_q      <= ST_DATA;
            end else begin
              bit_cnt_q <= bit_cnt_q + 4'd1;
            end
          end
        end
        ST_DATA: begin
          if (rx_edge) begin
            rx_q <= rx_nxt;
            if (bit_cnt_q == LAST_DATA) begin
              bit_cnt_q <= '0;
              addr_q    <= addr_step;
              if (!stream_q) begin
                if (left_q == 2'd0) begin
                  st_q <= ST_DONE;
                  oe_q <= 1'b0;
                end else begin
                  left_q <= left_q - 2'd1;
                end
              end
            end else begin
              bit_cnt_q <= bit_cnt_q + 4'd1;
            end
          end else if (tx_edge && rd_q) begin
            sdo_q <= rd_data_i[tx_sel];
            oe_q  <= 1'b1;
          end else if (csb_rise && stream_q) begin
            // partial byte in rx_q is dropped
            st_q      <= ST_IDLE;
            oe_q      <= 1'b0;
            bit_cnt_q <= '0;
          end
        end
        ST_DONE: if (csb_i) st_q <= ST_IDLE;
        default: st_q <= ST_IDLE;
      endcase
    end
  end

  assign rd_addr_o = addr_q;
  assign we_o      = byte_done & ~rd_q;
  assign wr_addr_o = addr_q;
  assign wr_data_o = rx_nxt;
  assign sdo_o     = sdo_q;
  assign sdo_oe_o  = oe_q & ~csb_i;

  p_oe_read_only_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    oe_q |-> rd_q);
  p_oe_data_phase_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q != ST_DATA) |-> !oe_q);
  p_addr_dec_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (byte_done && !lsb_q) |=> addr_q == ADDR_BITS'($past(addr_q) - 1'b1));
  p_addr_inc_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (byte_done && lsb_q) |=> addr_q == ADDR_BITS'($past(addr_q) + 1'b1));
  p_count_end_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (byte_done && !stream_q && left_q == 2'd0) |=> st_q == ST_DONE);
  p_stream_end_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (csb_rise && st_q == ST_DATA && stream_q) |=> st_q == ST_IDLE);
  p_pause_keeps_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (csb_rise && st_q == ST_DATA && !stream_q) |=> st_q == ST_DATA);
endmodule

// File: rtl/spi_cfg_slave.sv
module spi_cfg_slave
  import spi_cfg_pkg::*;
#(
  parameter int REG_DEPTH   = 16,
  parameter int SYNC_STAGES = 2,
  parameter int CFG_ADDR    = 0,
  parameter int LSB_BIT     = 6
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic sclk_i,
  input  logic csb_ni,
  input  logic sdio_i,
  output logic sdio_o,
  output logic sdio_oe_o
);
  logic [2:0]           pins_s;
  logic                 we, lsb_first;
  logic [ADDR_BITS-1:0] wr_addr, rd_addr;
  logic [7:0]           wr_data, rd_data;

  spi_cfg_sync #(
    .W(3), .STAGES(SYNC_STAGES), .RST_VAL(3'b100)
  ) u_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .din_i ({csb_ni, sclk_i, sdio_i}),
    .dout_o(pins_s)
  );

  spi_cfg_frame u_frame (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .sclk_i   (pins_s[1]),
    .csb_i    (pins_s[2]),
    .sdi_i    (pins_s[0]),
    .lsb_cfg_i(lsb_first),
    .rd_data_i(rd_data),
    .rd_addr_o(rd_addr),
    .we_o     (we),
    .wr_addr_o(wr_addr),
    .wr_data_o(wr_data),
    .sdo_o    (sdio_o),
    .sdo_oe_o (sdio_oe_o)
  );

  spi_cfg_regs #(
    .DEPTH(REG_DEPTH), .ADDR_W(ADDR_BITS), .CFG_ADDR(CFG_ADDR), .LSB_BIT(LSB_BIT)
  ) u_regs (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .we_i       (we),
    .wr_addr_i  (wr_addr),
    .wr_data_i  (wr_data),
    .rd_addr_i  (rd_addr),
    .rd_data_o  (rd_data),
    .lsb_first_o(lsb_first)
  );
endmodule

// File: tb/spi_cfg_slave_test.sv
module spi_cfg_slave_test;
  localparam int HALF = 8;

  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic rst_n, sclk, csb_n, sdio_mi;
  logic sdio_so, sdio_oe;

  spi_cfg_slave uut (
    .clk_i(clk), .rst_ni(rst_n), .sclk_i(sclk), .csb_ni(csb_n),
    .sdio_i(sdio_mi), .sdio_o(sdio_so), .sdio_oe_o(sdio_oe)
  );

  logic [7:0] model [16];
  logic [7:0] exp_v [$];
  string      exp_tag [$];
  int  checks = 0, fails = 0, cyc = 0, oe_bad = 0, mon_cnt = 0;
  bit  frame_lsb = 0, wr_frame = 0, done = 0;
  logic [7:0] mon_byte = 8'h00;

  task automatic check(bit ok, string tag, int act, int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: got %0h expected %0h", tag, act, exp);
    end
  endtask

  function automatic logic [7:0] model_rd(logic [12:0] a);
    return (a < 13'd16) ? model[a[3:0]] : 8'h00;
  endfunction

  task automatic half();
    repeat (HALF) @(negedge clk);
  endtask

  task automatic clk_bit(logic b);
    sdio_mi = b; half(); sclk = 1'b1; half(); sclk = 1'b0;
  endtask

  // driver: pushes expected read bytes, updates the write model
  task automatic xfer(bit rd, logic [1:0] len, logic [12:0] addr, logic [47:0] data,
                      int nbytes, int tail, bit pause, string tag);
    logic [15:0] iw;
    logic [12:0] a;
    logic [7:0]  d;
    bit lsb, counted;
    lsb = model[0][6];
    frame_lsb = lsb;
    iw = {rd, len, addr};
    a = addr;
    wr_frame = !rd;
    oe_bad = 0;
    csb_n = 1'b0; half();
    for (int i = 0; i < 16; i++) clk_bit(lsb ? iw[i] : iw[15-i]);
    for (int k = 0; k < nbytes; k++) begin
      if (pause && k > 0) begin
        csb_n = 1'b1; half(); half(); csb_n = 1'b0; half();
      end
      counted = (len == 2'b11) || (k <= int'(len));
      d = data[8*k +: 8];
      if (rd) begin
        if (counted) begin exp_v.push_back(model_rd(a)); exp_tag.push_back(tag); end
        for (int i = 0; i < 8; i++) clk_bit(1'b0);
      end else begin
        for (int i = 0; i < 8; i++) clk_bit(lsb ? d[i] : d[7-i]);
        if (counted && a < 13'd16) model[a[3:0]] = d;
      end
      a = lsb ? a + 13'd1 : a - 13'd1;
    end
    for (int i = 0; i < tail; i++) clk_bit(1'b1);
    half(); csb_n = 1'b1; half(); half();
    if (rd) check(exp_v.size() == 0, {tag, " bytes driven"}, exp_v.size(), 0);
    else    check(oe_bad == 0, {"R10 ", tag}, oe_bad, 0);
    check(sdio_oe == 1'b0, "R10 oe low with select high", int'(sdio_oe), 0);
    wr_frame = 0;
  endtask

  // monitor: collects driven bits on host sampling edge and scores bytes
  always @(posedge sclk) begin
    if (sdio_oe) begin
      if (wr_frame) oe_bad++;
      mon_byte = frame_lsb ? {sdio_so, mon_byte[7:1]} : {mon_byte[6:0], sdio_so};
      mon_cnt++;
      if (mon_cnt == 8) begin
        mon_cnt = 0;
        if (exp_v.size() == 0) check(1'b0, "R5 unexpected byte", int'(mon_byte), 0);
        else begin
          automatic logic [7:0] e = exp_v.pop_front();
          automatic string t = exp_tag.pop_front();
          check(mon_byte == e, t, int'(mon_byte), int'(e));
        end
      end
    end
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc == 150000 && !done) begin
      done = 1;
      checks++; fails++;
      $display("FAIL watchdog: got %0d expected 0", cyc);
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < 16; i++) model[i] = 8'h00;
    rst_n = 1'b0; sclk = 1'b0; csb_n = 1'b1; sdio_mi = 1'b0;
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);
    check(sdio_oe == 1'b0, "R1 oe after reset", int'(sdio_oe), 0);
    xfer(1, 2'b10, 13'd2, 48'h0, 3, 0, 0, "R1");
    // one-byte write with a spare byte clocked after it
    xfer(0, 2'b00, 13'd5, 48'hFFA5, 2, 0, 0, "R3");
    xfer(1, 2'b00, 13'd4, 48'h0, 1, 0, 0, "R3");
    xfer(1, 2'b00, 13'd5, 48'h0, 1, 0, 0, "R2");
    xfer(0, 2'b10, 13'd9, 48'h332211, 3, 0, 0, "R4");
    xfer(1, 2'b10, 13'd9, 48'h0, 3, 0, 0, "R4");
    xfer(0, 2'b01, 13'd12, 48'h5544, 2, 0, 1, "R7");
    xfer(1, 2'b01, 13'd12, 48'h0, 2, 0, 0, "R7");
    // stream write with a trailing half byte
    xfer(0, 2'b11, 13'd15, 48'h6463626160, 5, 4, 0, "R6");
    xfer(1, 2'b11, 13'd15, 48'h0, 6, 0, 0, "R6");
    xfer(1, 2'b01, 13'd0, 48'h0, 2, 0, 0, "R4");
    xfer(0, 2'b00, 13'h100, 48'h77, 1, 0, 0, "R9");
    xfer(1, 2'b00, 13'h100, 48'h0, 1, 0, 0, "R9");
    xfer(1, 2'b00, 13'd0, 48'h0, 1, 0, 0, "R9");
    // switch to LSB-first order
    xfer(0, 2'b00, 13'd0, 48'h40, 1, 0, 0, "R8");
    xfer(1, 2'b00, 13'd0, 48'h0, 1, 0, 0, "R8");
    xfer(0, 2'b10, 13'd3, 48'hC30281, 3, 0, 0, "R8");
    xfer(1, 2'b10, 13'd3, 48'h0, 3, 0, 0, "R8");
    xfer(1, 2'b11, 13'd13, 48'h0, 3, 0, 0, "R8");
    xfer(0, 2'b00, 13'd0, 48'h00, 1, 0, 0, "R8");
    xfer(1, 2'b01, 13'd5, 48'h0, 2, 0, 0, "R2");
    if (!done) begin
      done = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end
endmodule